// File: doc/BRIEF.md
# Radix-b Approximate-Quotient Modular Multiplier

This block computes P = X·Y mod D for unsigned operands of N digits, each digit W bits wide (radix b = 2^W). It works one multiplier digit at a time, starting with the most significant digit. Each step forms b·P + X·y_i. It then estimates a quotient from the two digits just below the overflow digit, dividing them by the top modulus digit plus one, and subtracts that multiple of D. A nonzero overflow digit above the n+1 low digits is folded back in by adding a stored residue i·b^(n+1) mod D. A final loop subtracts D until the result is below D.

Each operation first rebuilds its six-entry residue table from the modulus. The first entry uses the same estimate-and-subtract datapath. Each later entry is the previous entry plus the first, followed by one conditional subtraction of D. The caller presents X, Y and D with a one-cycle start pulse and then waits for the completion pulse. D must be normalized: its top digit lies between b/2 and b−1. X and Y must be below D.

Top module: `amm_modmul`

## Requirements
- R1: `done` is high for exactly one cycle per operation, and `result` keeps its value from that cycle until the next operation completes.
- R2: For a normalized D (top digit in [b/2, b−1]) and X, Y < D, `result` equals X·Y mod D. The multiplier digits are consumed from the most significant digit down.
- R3: When the top digit of D equals b−1, the quotient estimate is taken directly as the second-highest working digit and the digit divider never runs. The result is still X·Y mod D.
- R4: The quotient estimate, floor((2 working digits)/(top D digit + 1)), is below 2b, so its high digit is at most 1.
- R5: After q·D is subtracted, the low n+1-digit part of the working value lies in [0, 5D).
- R6: In the main loop the overflow digit is never above 6. A nonzero overflow digit is replaced by its table residue.
- R7: Every residue table entry written is below D.
- R8: A `start` pulse while an operation is in progress is ignored. The running operation completes with its own operands.
- R9: After reset, `done` is 0 and `result` is 0.
- R10: A zero operand yields 0, and X = Y = D−1 yields 1, including for D = b^n − 1 and D = b^n/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| opa | input | N·W | Multiplicand X |
| opb | input | N·W | Multiplier Y, consumed digit by digit from the top |
| modulus | input | N·W | Normalized modulus D |
| done | output | 1 | One-cycle completion pulse |
| result | output | N·W | X·Y mod D, held until the next completion |

## Verification
The hardest conditions to reach from the ports are an overflow digit near its bound of 6 and a reduced value close to 5D. Both need a modulus whose top digit sits at b/2, with working digits near b−1. The random stimulus therefore draws top digits from the whole normalized range and adds directed cases with D at exactly b^n/2 and X = Y = D−1. A separate group fixes the top digit at b−1 to drive the path that skips the divider. A start pulse injected mid-operation with different operands checks that the latched operands are used.

// File: rtl/amm_pkg.sv
// Shared types for the approximate-quotient modular multiplier.
// Assumes nothing beyond the parameters of the instantiating module.
package amm_pkg;
    // Number of residue table entries (i * b^(n+1) mod D, i = 1..6).
    localparam int TAB_N = 6;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_QSEL,   // choose quotient path: bypass or divider
        ST_QWAIT,  // waiting for the digit divider
        ST_APPLY,  // subtract q*D, fold overflow digit
        ST_SHIFT,  // P <- b*P + X*y_i
        ST_FIX,    // subtract D while P >= D
        ST_BUILD   // fill table entries 2..6
    } amm_state_e;

    // Which pass the shared datapath is serving.
    typedef enum logic {
        PH_TABLE,  // forming b^(n+1) mod D
        PH_MAIN    // digit-serial multiply
    } amm_phase_e;
endpackage

// File: rtl/amm_qdiv.sv
// Restoring divider: a 2W-bit dividend over a (W+1)-bit divisor, one
// quotient bit per cycle, 2W cycles in all.
// Assumes: den is nonzero and go is raised only while busy is low.
module amm_qdiv #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [2*W-1:0]   num,
    input  logic [W:0]       den,
    output logic             busy,
    output logic             fin,
    output logic [2*W-1:0]   quo
);
    localparam int NB = 2 * W;
    localparam int CW = $clog2(NB + 1);

    logic [W+1:0]  rem_r;
    logic [NB-1:0] num_r;
    logic [NB-1:0] quo_r;
    logic [W:0]    den_r;
    logic [CW-1:0] cnt_r;
    logic          busy_r;
    logic          fin_r;

    logic [W+1:0]  rem_sh;
    logic          take;
    logic [W+1:0]  rem_nx;

    // Purpose: one restoring step (shift in the next dividend bit, trial subtract).
    always_comb begin
        rem_sh = {rem_r[W:0], num_r[NB-1]};
        take   = (rem_sh >= {1'b0, den_r});
        rem_nx = take ? (rem_sh - {1'b0, den_r}) : rem_sh;
    end

    // Purpose: load the operands on go, then iterate until every bit is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r  <= '0;
            num_r  <= '0;
            quo_r  <= '0;
            den_r  <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            fin_r  <= 1'b0;
        end else begin
            fin_r <= 1'b0;
            if (go && !busy_r) begin
                rem_r  <= '0;
                num_r  <= num;
                quo_r  <= '0;
                den_r  <= den;
                cnt_r  <= CW'(NB);
                busy_r <= 1'b1;
            end else if (busy_r) begin
                rem_r <= rem_nx;
                quo_r <= {quo_r[NB-2:0], take};
                num_r <= {num_r[NB-2:0], 1'b0};
                cnt_r <= cnt_r - CW'(1);
                if (cnt_r == CW'(1)) begin
                    busy_r <= 1'b0;
                    fin_r  <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_r;
    assign fin  = fin_r;
    assign quo  = quo_r;

    // R4 (the partial remainder stays below the divisor while iterating)
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_r |=> (rem_r < {1'b0, den_r}));
endmodule

// File: rtl/amm_restab.sv
// Residue table: TAB_N entries of N*W bits, one write port and two
// read ports. Index 0 and indices above TAB_N read as zero.
// Assumes the writer supplies already-reduced values.
module amm_restab import amm_pkg::*; #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(TAB_N+1)-1:0]   wr_idx,
    input  logic [N*W-1:0]               wr_val,
    input  logic [$clog2(TAB_N+1)-1:0]   rda_idx,
    output logic [N*W-1:0]               rda_val,
    input  logic [$clog2(TAB_N+1)-1:0]   rdb_idx,
    output logic [N*W-1:0]               rdb_val
);
    localparam int NW    = N * W;
    localparam int IW    = $clog2(TAB_N + 1);
    localparam int SLOTS = 1 << IW;

    logic [NW-1:0] ent [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g >= 1 && g <= TAB_N) begin : g_reg
            // Purpose: hold one residue entry, replaced when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[g] <= '0;
                end else if (wr_en && (wr_idx == IW'(g))) begin
                    ent[g] <= wr_val;
                end
            end
        end else begin : g_zero
            assign ent[g] = '0;
        end
    end

    assign rda_val = ent[rda_idx];
    assign rdb_val = ent[rdb_idx];
endmodule

// File: rtl/amm_modmul.sv
// Digit-serial modular multiplier with an approximate quotient.
// For each operation: build the table i*b^(n+1) mod D, then run N steps of
// P <- b*P + X*y_i, q ~ floor(top two low digits / (d_top+1)),
// P' <- P' - q*D, fold the overflow digit through the table, and finally
// subtract D while P >= D.
// Assumes: modulus top digit in [b/2, b-1], opa and opb below modulus.
module amm_modmul import amm_pkg::*; #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N*W-1:0] opa,
    input  logic [N*W-1:0] opb,
    input  logic [N*W-1:0] modulus,
    output logic           done,
    output logic [N*W-1:0] result
);
    localparam int NW = N * W;
    localparam int LW = (N + 1) * W;
    localparam int PW = (N + 2) * W;
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam int IW = $clog2(TAB_N + 1);
    localparam logic [W-1:0] DMAX = '1;

    amm_state_e    state;
    amm_phase_e    phase;
    logic [NW-1:0] x_r, y_r, d_r;
    logic [PW-1:0] acc;
    logic [W:0]    q_r;
    logic [CW-1:0] dig;
    logic [IW-1:0] k_r;
    logic          done_r;
    logic [NW-1:0] res_r;

    // Datapath signals.
    logic [W-1:0]   d_top, hi_ovf, ydig;
    logic [LW-1:0]  lowp;
    logic [2*W-1:0] top2;
    logic [W:0]     div_den;
    logic [PW-1:0]  pre_val, qd, red_low, apply_val, shift_val, five_d, d_ext;
    logic           acc_ge_d;
    logic [NW:0]    build_sum;
    logic [NW-1:0]  build_val;

    // Divider and table wiring.
    logic           div_go, div_busy, div_fin;
    logic [2*W-1:0] div_quo;
    logic           tab_we;
    logic [IW-1:0]  tab_widx, tab_ridx;
    logic [NW-1:0]  tab_wval, e_sel, e_one;

    // Purpose: slice the working value and the modulus into the fields the steps use.
    always_comb begin
        d_top   = d_r[NW-1 -: W];
        hi_ovf  = acc[PW-1 -: W];
        lowp    = acc[LW-1:0];
        top2    = acc[LW-1 -: 2*W];
        ydig    = y_r[int'(dig)*W +: W];
        div_den = {1'b0, d_top} + (W+1)'(1);
        d_ext   = PW'(d_r);
        five_d  = (d_ext << 2) + d_ext;
    end

    // Purpose: starting value b^(n+1) - b*D for the table pass.
    always_comb begin
        pre_val = (PW'(1) << LW) - (PW'(modulus) << W);
    end

    // Purpose: reduction step, subtract q*D and fold in the overflow residue.
    always_comb begin
        qd        = PW'(q_r) * d_ext;
        red_low   = PW'(lowp) - qd;
        apply_val = ((phase == PH_MAIN) && (hi_ovf != '0))
                    ? (red_low + PW'(e_sel)) : red_low;
    end

    // Purpose: shift in the next digit product.
    always_comb begin
        shift_val = (acc << W) + (PW'(x_r) * PW'(ydig));
        acc_ge_d  = (acc >= d_ext);
    end

    // Purpose: next table entry, e[k-1] + e[1] with one conditional subtract.
    always_comb begin
        build_sum = {1'b0, e_sel} + {1'b0, e_one};
        build_val = (build_sum >= {1'b0, d_r})
                    ? NW'(build_sum - {1'b0, d_r}) : build_sum[NW-1:0];
    end

    // Purpose: table port control for the first entry (end of FIX) and for entries 2..6 (BUILD).
    always_comb begin
        tab_we   = ((state == ST_FIX) && (phase == PH_TABLE) && !acc_ge_d)
                   || (state == ST_BUILD);
        tab_widx = (state == ST_BUILD) ? k_r : IW'(1);
        tab_wval = (state == ST_BUILD) ? build_val : acc[NW-1:0];
        tab_ridx = (state == ST_BUILD) ? (k_r - IW'(1)) : hi_ovf[IW-1:0];
        div_go   = (state == ST_QSEL) && (d_top != DMAX);
    end

    amm_qdiv #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (top2),
        .den   (div_den),
        .busy  (div_busy),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    amm_restab #(.W(W), .N(N)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tab_we),
        .wr_idx  (tab_widx),
        .wr_val  (tab_wval),
        .rda_idx (tab_ridx),
        .rda_val (e_sel),
        .rdb_idx (IW'(1)),
        .rdb_val (e_one)
    );

    // Purpose: sequence the table pass, the digit loop and the final correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= PH_TABLE;
            x_r    <= '0;
            y_r    <= '0;
            d_r    <= '0;
            acc    <= '0;
            q_r    <= '0;
            dig    <= '0;
            k_r    <= '0;
            done_r <= 1'b0;
            res_r  <= '0;
        end else begin
            done_r <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        x_r   <= opa;
                        y_r   <= opb;
                        d_r   <= modulus;
                        acc   <= pre_val;
                        phase <= PH_TABLE;
                        state <= ST_QSEL;
                    end
                end
                ST_QSEL: begin
                    if (d_top == DMAX) begin
                        q_r   <= {1'b0, acc[LW-1 -: W]};
                        state <= ST_APPLY;
                    end else begin
                        state <= ST_QWAIT;
                    end
                end
                ST_QWAIT: begin
                    if (div_fin) begin
                        q_r   <= div_quo[W:0];
                        state <= ST_APPLY;
                    end
                end
                ST_APPLY: begin
                    acc <= apply_val;
                    if (phase == PH_TABLE || dig == '0) begin
                        state <= ST_FIX;
                    end else begin
                        dig   <= dig - CW'(1);
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    acc   <= shift_val;
                    state <= ST_QSEL;
                end
                ST_FIX: begin
                    if (acc_ge_d) begin
                        acc <= acc - d_ext;
                    end else if (phase == PH_TABLE) begin
                        k_r   <= IW'(2);
                        state <= ST_BUILD;
                    end else begin
                        res_r  <= acc[NW-1:0];
                        done_r <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_BUILD: begin
                    if (k_r == IW'(TAB_N)) begin
                        acc   <= '0;
                        dig   <= CW'(N - 1);
                        phase <= PH_MAIN;
                        state <= ST_SHIFT;
                    end else begin
                        k_r <= k_r + IW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done   = done_r;
    assign result = res_r;

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |=> !done_r);
    // R1
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |-> (res_r < d_r));
    // R3
    bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && state != ST_IDLE) |-> (d_top != DMAX));
    // R4
    qhigh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_fin |-> (div_quo[2*W-1:W+1] == '0));
    // R5
    red_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_APPLY) |-> (qd <= PW'(lowp)));
    // R5
    red_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_APPLY) |-> (red_low < five_d));
    // R6
    ovf_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_APPLY && phase == PH_MAIN) |-> (hi_ovf <= W'(TAB_N)));
    // R7
    tab_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tab_we |-> (tab_wval < d_r));
endmodule

// File: tb/amm_modmul_test.sv
`timescale 1ns/1ps
module amm_modmul_test;
    localparam int W  = 8;
    localparam int N  = 4;
    localparam int NW = N * W;
    localparam int OP_LIMIT = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] opa = '0, opb = '0, modulus = '0;
    logic          done;
    logic [NW-1:0] result;

    int checks = 0;
    int errors = 0;
    bit summary_done = 0;

    always #2.5 clk = ~clk;

    amm_modmul #(.W(W), .N(N)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .opa(opa), .opb(opb), .modulus(modulus),
        .done(done), .result(result)
    );

    function automatic logic [NW-1:0] ref_mod(input logic [NW-1:0] x,
                                              input logic [NW-1:0] y,
                                              input logic [NW-1:0] d);
        logic [2*NW-1:0] prod;
        prod = {{NW{1'b0}}, x} * {{NW{1'b0}}, y};
        return NW'(prod % {{NW{1'b0}}, d});
    endfunction

    task automatic check(input string tag, input logic [NW-1:0] got,
                         input logic [NW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Waits for done; returns 1 if it arrived.
    task automatic wait_done(output bit ok);
        int n = 0;
        ok = 0;
        while (n < OP_LIMIT) begin
            @(negedge clk);
            if (done) begin
                ok = 1;
                break;
            end
            n++;
        end
    endtask

    task automatic run_op(input string tag, input logic [NW-1:0] x,
                          input logic [NW-1:0] y, input logic [NW-1:0] d);
        bit ok;
        @(negedge clk);
        opa = x; opb = y; modulus = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        if (!ok) begin
            checks++; errors++;
            $display("FAIL %s: got timeout expected done", tag);
        end else begin
            check(tag, result, ref_mod(x, y, d));
        end
    endtask

    function automatic logic [NW-1:0] rnd_mod(input bit top_max);
        logic [NW-1:0] d;
        d = $urandom;
        d[NW-1 -: W] = top_max ? W'((1 << W) - 1) : W'((1 << (W-1)) + ($urandom % (1 << (W-1))));
        return d;
    endfunction

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: got running expected finished");
        finish_run();
    end

    initial begin
        logic [NW-1:0] d, x, y, hold;
        bit ok;
        int seed;
        seed = $urandom(32'h5A17C3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        checks++;
        if (done !== 1'b0) begin errors++; $display("FAIL R9: got done=%b expected 0", done); end
        check("R9 result", result, '0);

        // R10: directed corners
        d = 32'hFFFF_FFFF;
        run_op("R10 zero x", '0, 32'h1234_5678, d);
        run_op("R10 zero y", 32'h0BAD_F00D, '0, d);
        run_op("R10 max ones", d - 1, d - 1, d);
        d = 32'h8000_0000;
        run_op("R10 min norm", d - 1, d - 1, d);
        run_op("R10 unit", 32'h1, 32'h1, d);
        check("R10 expect one", ref_mod(d - 1, d - 1, d), 32'h1);

        // R3: top digit b-1, quotient bypass path
        for (int i = 0; i < 40; i++) begin
            d = rnd_mod(1'b1);
            x = $urandom % d; y = $urandom % d;
            run_op("R3", x, y, d);
        end

        // R2 with R4,R5,R6,R7 guarded inside: full normalized range
        for (int i = 0; i < 150; i++) begin
            d = rnd_mod(1'b0);
            x = $urandom % d; y = $urandom % d;
            run_op("R2,R4,R5,R6,R7 random", x, y, d);
        end
        // R6 stress: smallest top digit with operands near D
        for (int i = 0; i < 20; i++) begin
            d = {W'(1 << (W-1)), (NW-W)'($urandom)};
            run_op("R6 near bound", d - 1 - NW'(i), d - 2, d);
        end

        // R8: start while busy is ignored; R1: done pulse and result hold
        d = 32'hC123_4567; x = 32'h8765_4321 % d; y = 32'h3141_5926;
        @(negedge clk);
        opa = x; opb = y; modulus = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        opa = 32'h1111_1111; opb = 32'h2222_2222; modulus = 32'hF000_0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        checks++;
        if (!ok) begin errors++; $display("FAIL R8: got timeout expected done"); end
        check("R8", result, ref_mod(x, y, d));
        hold = result;
        @(negedge clk);
        checks++;
        if (done !== 1'b0) begin errors++; $display("FAIL R1: got done=%b expected 0", done); end
        repeat (5) @(negedge clk);
        check("R1 hold", result, hold);

        finish_run();
    end
endmodule